// File: doc/BRIEF.md
# Embedded-Controller Command Queue Sequencer

This block sits between a host that produces command messages for an embedded controller and the byte-level link engine that moves them. It keeps a first-in first-out queue of outgoing command descriptors. For the message at the head of the queue it pulls an active-low request line to ask the controller for service. It then waits until the link engine reports that the transfer has finished, and at that point it drops the head. If the transfer does not finish within a millisecond budget, the block lets go of the request line for one cycle, rewinds the head's byte position to zero, and asks again for the same message. It retries like this for as long as the transfer keeps failing.

Each descriptor carries the payload byte count, which is also the length prefix of the frame on the wire, and the first two command bytes. The total frame size is one more than the payload count. A command can be marked synchronous. For such a command the block stores a 16-bit tag made of its two first bytes, the second byte in the upper half. Only one synchronous command can be outstanding at a time. The block looks at every message the controller sends back. A message whose header byte and third byte form the stored tag is sent to the synchronous-response port, and the tag is then cleared. Every other message is reported on the event port, with the header masked to its class bits. If no match arrives within its own millisecond budget, the synchronous command completes with a failure status.

Top module: `ecq_top`

## Requirements
- R1: After reset `req_n` is 1, `head_valid` is 0, `enq_ready` is 1, and `rsp_valid`, `evt_valid` and `sync_done` are 0.
- R2: An accepted command shows at the head with `head_len` equal to its payload count and `head_total` equal to payload count plus one.
- R3: The queue holds DEPTH commands and serves them in arrival order. When the queue is full, `enq_ready` is 0 and the offered command is not stored.
- R4: While the queue is not empty, `req_n` goes to 0 for the head within two cycles. `req_n` never falls while the queue is empty.
- R5: A `xfer_done` pulse while `req_n` is 0 removes the head, and `req_n` is 1 in the following cycle. A `xfer_done` pulse while `req_n` is 1 is ignored.
- R6: While `req_n` is 0, each `byte_adv` cycle increments `head_pos`, which stops at `head_total`. `head_pos` starts at 0 for every new request.
- R7: If `xfer_done` does not arrive within TX_MS milliseconds of the request, `req_n` is 1 for exactly one cycle with `head_pos` at 0. `req_n` then goes back to 0 for the same head.
- R8: An accepted command with `enq_sync` at 1 stores the tag {enq_c1, enq_c0}. While that tag is pending, `enq_ready` is 0 for another synchronous command and stays 1 for an ordinary one.
- R9: A received message with {rx_b2, rx_hdr} equal to the pending tag gives a one-cycle pulse of `rsp_valid`, with `sync_done` at 1 and `sync_ok` at 1, one cycle later. The tag is then cleared, so the same message arriving again becomes an event.
- R10: Every other received message gives a one-cycle pulse of `evt_valid`, with `evt_code` equal to `rx_hdr` AND 8'h8F, one cycle later. `rsp_valid` and `evt_valid` are never both 1.
- R11: If no matching message arrives within SYNC_MS milliseconds, `sync_done` pulses with `sync_ok` at 0 and the tag is cleared.
- R12: The budgets are counted in millisecond ticks of CLK_HZ/1000 cycles. A timeout fires after more than (budget-1) and at most budget milliseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Host offers a command |
| enq_sync | input | 1 | Offered command is synchronous |
| enq_len | input | 8 | Payload byte count of the command |
| enq_c0 | input | 8 | First command byte (low half of the tag) |
| enq_c1 | input | 8 | Second command byte (high half of the tag) |
| enq_ready | output | 1 | Command would be accepted this cycle |
| req_n | output | 1 | Active-low service request to the controller |
| head_valid | output | 1 | Queue holds at least one command |
| head_len | output | 8 | Payload count of the head |
| head_total | output | 9 | Frame size of the head (payload plus length byte) |
| head_pos | output | 9 | Byte position of the head transfer |
| byte_adv | input | 1 | Link engine moved one byte of the head |
| xfer_done | input | 1 | Link engine finished the head transfer |
| rx_valid | input | 1 | A received message is presented |
| rx_hdr | input | 8 | Byte 0 of the received message |
| rx_b2 | input | 8 | Byte 2 of the received message |
| rsp_valid | output | 1 | Received message answered the synchronous command |
| evt_valid | output | 1 | Received message goes to the event port |
| evt_code | output | 8 | Event class code |
| sync_done | output | 1 | Synchronous command finished |
| sync_ok | output | 1 | Synchronous command finished with a match |

## Verification
The queue is driven with a fixed-seed random mix of command lengths, burst sizes and byte-advance counts. This separates correct ordering and frame sizing from position saturation. Directed sequences fill the queue to overflow, pulse `xfer_done` on an idle line, and withhold `xfer_done` until the retry timeout. These show apart the dropped, ignored and rewound cases. Received traffic uses random tags in which half the messages match. Against those sit directed near misses that differ only in byte 2, a repeated match after the tag is cleared, and a silent period that forces the synchronous failure. Together these show whether the tag compare uses both bytes and whether it is cleared on a match.

// File: rtl/ecq_pkg.sv
package ecq_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    byte_t len;
    byte_t c1;
    byte_t c0;
  } cmd_desc_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DROP} seq_state_t;

  // frame on the wire: one length byte plus the payload
  function automatic logic [8:0] frame_total(input byte_t len);
    return {1'b0, len} + 9'd1;
  endfunction

  function automatic logic [15:0] make_tag(input byte_t lo, input byte_t hi);
    return {hi, lo};
  endfunction

  function automatic byte_t event_code(input byte_t hdr);
    return hdr & 8'h8F;
  endfunction
endpackage

// File: rtl/ecq_ms_tick.sv
module ecq_ms_tick #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick
);
  localparam int TPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int CW  = $clog2(TPM + 1);

  logic [CW-1:0] cnt;

  assign ms_tick = (cnt == CW'(TPM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (ms_tick) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ecq_fifo.sv
module ecq_fifo
  import ecq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  cmd_desc_t din,
  input  logic      pop,
  output cmd_desc_t dout,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  cmd_desc_t     mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/ecq_tx_seq.sv
module ecq_tx_seq
  import ecq_pkg::*;
#(
  parameter int TX_MS = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       have_msg,
  input  logic [8:0] head_total,
  input  logic       xfer_done,
  input  logic       byte_adv,
  input  logic       ms_tick,
  output logic       req_n,
  output logic       pop,
  output logic       tx_timeout,
  output logic [8:0] head_pos
);
  localparam int MW = $clog2(TX_MS + 1);

  seq_state_t    state;
  logic [MW-1:0] ms_cnt;

  assign req_n      = (state != SQ_WAIT);
  assign pop        = (state == SQ_WAIT) && xfer_done;
  assign tx_timeout = (state == SQ_WAIT) && !xfer_done && ms_tick &&
                      (ms_cnt == MW'(TX_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ms_cnt   <= '0;
      head_pos <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          head_pos <= '0;
          ms_cnt   <= '0;
          if (have_msg) state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (pop) begin
            state    <= SQ_IDLE;
            head_pos <= '0;
          end else if (tx_timeout) begin
            state    <= SQ_DROP;
            head_pos <= '0;
          end else begin
            if (ms_tick) ms_cnt <= ms_cnt + 1'b1;
            if (byte_adv && head_pos < head_total) head_pos <= head_pos + 1'b1;
          end
        end
        default: begin
          ms_cnt <= '0;
          state  <= SQ_WAIT;
        end
      endcase
    end
  end

  p_fall_needs_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(have_msg));
  p_release_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> req_n);
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> head_pos <= head_total);
  p_timeout_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |=> (req_n && head_pos == 9'd0));
endmodule

// File: rtl/ecq_router.sv
module ecq_router
  import ecq_pkg::*;
#(
  parameter int SYNC_MS = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_arm,
  input  logic [15:0] arm_tag,
  input  logic        rx_valid,
  input  byte_t       rx_hdr,
  input  byte_t       rx_b2,
  input  logic        ms_tick,
  output logic        busy,
  output logic        rsp_valid,
  output logic        evt_valid,
  output byte_t       evt_code,
  output logic        sync_done,
  output logic        sync_ok
);
  localparam int MW = $clog2(SYNC_MS + 1);

  logic [15:0]   tag;
  logic [MW-1:0] ms_cnt;
  logic          hit, expire;

  assign hit    = rx_valid && busy && (make_tag(rx_hdr, rx_b2) == tag);
  assign expire = busy && !hit && ms_tick && (ms_cnt == MW'(SYNC_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tag       <= '0;
      ms_cnt    <= '0;
      rsp_valid <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      sync_done <= 1'b0;
      sync_ok   <= 1'b0;
    end else begin
      rsp_valid <= hit;
      evt_valid <= rx_valid && !hit;
      evt_code  <= (rx_valid && !hit) ? event_code(rx_hdr) : 8'h00;
      sync_done <= hit || expire;
      sync_ok   <= hit;
      if (sync_arm) begin
        busy   <= 1'b1;
        tag    <= arm_tag;
        ms_cnt <= '0;
      end else if (hit || expire) begin
        busy <= 1'b0;
        tag  <= '0;
      end else if (busy && ms_tick) begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end

  p_clear_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!busy && rsp_valid && sync_ok));
  p_one_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, evt_valid}));
  p_evt_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code[6:4] == 3'b000));
  p_expire_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (sync_done && !sync_ok && !busy));
endmodule

// File: rtl/ecq_top.sv
module ecq_top
  import ecq_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int DEPTH   = 4,
  parameter int TX_MS   = 5000,
  parameter int SYNC_MS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enq_valid,
  input  logic       enq_sync,
  input  logic [7:0] enq_len,
  input  logic [7:0] enq_c0,
  input  logic [7:0] enq_c1,
  output logic       enq_ready,
  output logic       req_n,
  output logic       head_valid,
  output logic [7:0] head_len,
  output logic [8:0] head_total,
  output logic [8:0] head_pos,
  input  logic       byte_adv,
  input  logic       xfer_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_hdr,
  input  logic [7:0] rx_b2,
  output logic       rsp_valid,
  output logic       evt_valid,
  output logic [7:0] evt_code,
  output logic       sync_done,
  output logic       sync_ok
);
  logic      ms_tick, push, pop, empty, full, sync_busy, sync_arm, tx_timeout;
  cmd_desc_t din, head;

  assign enq_ready  = !full && !(enq_sync && sync_busy);
  assign push       = enq_valid && enq_ready;
  assign sync_arm   = push && enq_sync;
  assign din        = '{len: enq_len, c1: enq_c1, c0: enq_c0};
  assign head_valid = !empty;
  assign head_len   = head.len;
  assign head_total = frame_total(head.len);

  ecq_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick));

  ecq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(pop),
    .dout(head), .empty(empty), .full(full));

  ecq_tx_seq #(.TX_MS(TX_MS)) u_seq (
    .clk(clk), .rst_n(rst_n), .have_msg(!empty), .head_total(head_total),
    .xfer_done(xfer_done), .byte_adv(byte_adv), .ms_tick(ms_tick),
    .req_n(req_n), .pop(pop), .tx_timeout(tx_timeout), .head_pos(head_pos));

  ecq_router #(.SYNC_MS(SYNC_MS)) u_router (
    .clk(clk), .rst_n(rst_n), .sync_arm(sync_arm),
    .arm_tag(make_tag(enq_c0, enq_c1)), .rx_valid(rx_valid),
    .rx_hdr(rx_hdr), .rx_b2(rx_b2), .ms_tick(ms_tick), .busy(sync_busy),
    .rsp_valid(rsp_valid), .evt_valid(evt_valid), .evt_code(evt_code),
    .sync_done(sync_done), .sync_ok(sync_ok));

  p_single_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_busy && push) |-> !enq_sync);
  p_head_kept_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |=> (head_valid && $stable(head_len)));
endmodule

// File: tb/ecq_top_bench.sv
module ecq_top_bench;
  localparam int CLK_HZ = 4000, TPM = 4, DEPTH = 4, TX_MS = 50, SYNC_MS = 20;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, enq_sync = 0, byte_adv = 0, xfer_done = 0, rx_valid = 0;
  logic [7:0] enq_len = 0, enq_c0 = 0, enq_c1 = 0, rx_hdr = 0, rx_b2 = 0;
  logic enq_ready, req_n, head_valid, rsp_valid, evt_valid, sync_done, sync_ok;
  logic [7:0] head_len, evt_code;
  logic [8:0] head_total, head_pos;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int q_len[$];

  always #5 clk = ~clk;

  ecq_top #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH), .TX_MS(TX_MS), .SYNC_MS(SYNC_MS)) u_ecq_top (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_sync(enq_sync),
    .enq_len(enq_len), .enq_c0(enq_c0), .enq_c1(enq_c1), .enq_ready(enq_ready),
    .req_n(req_n), .head_valid(head_valid), .head_len(head_len),
    .head_total(head_total), .head_pos(head_pos), .byte_adv(byte_adv),
    .xfer_done(xfer_done), .rx_valid(rx_valid), .rx_hdr(rx_hdr), .rx_b2(rx_b2),
    .rsp_valid(rsp_valid), .evt_valid(evt_valid), .evt_code(evt_code),
    .sync_done(sync_done), .sync_ok(sync_ok));

  function automatic int exp_total(int l); return l + 1; endfunction
  function automatic int exp_code(int h); return h & 'h8F; endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic enq(int l, int c0, int c1, bit s, output bit took);
    enq_valid = 1; enq_sync = s; enq_len = 8'(l); enq_c0 = 8'(c0); enq_c1 = 8'(c1);
    #1 took = enq_ready;
    @(negedge clk);
    enq_valid = 0; enq_sync = 0;
    if (took) q_len.push_back(l);
  endtask

  task automatic serve();
    int nb, tot, w;
    w = 0;
    while (req_n && w < 16) begin @(negedge clk); w++; end
    chk("R4 request low for head", req_n, 0);
    tot = exp_total(q_len[0]);
    chk("R2/R3 head_len in order", head_len, q_len[0]);
    chk("R2 head_total", head_total, tot);
    nb = $urandom_range(0, tot + 2);
    for (int i = 0; i < nb; i++) begin byte_adv = 1; @(negedge clk); end
    byte_adv = 0;
    chk("R6 head_pos", head_pos, (nb < tot) ? nb : tot);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    chk("R5 request released after done", req_n, 1);
    void'(q_len.pop_front());
  endtask

  task automatic rx(int h, int b2, bit exp_hit);
    rx_valid = 1; rx_hdr = 8'(h); rx_b2 = 8'(b2);
    @(negedge clk); rx_valid = 0;
    chk("R9 rsp_valid", rsp_valid, exp_hit);
    chk("R9 sync_done on match", sync_done, exp_hit);
    chk("R10 evt_valid", evt_valid, !exp_hit);
    if (exp_hit) chk("R9 sync_ok", sync_ok, 1);
    else         chk("R10 evt_code", evt_code, exp_code(h));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    bit took;
    int cnt, c0, c1, h, b2;
    bit pend;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_n", req_n, 1);
    chk("R1 head_valid", head_valid, 0);
    chk("R1 enq_ready", enq_ready, 1);
    chk("R1 rsp/evt/done", {rsp_valid, evt_valid, sync_done}, 0);

    // R5 done on an idle line is ignored
    xfer_done = 1; @(negedge clk); xfer_done = 0; @(negedge clk);
    chk("R5 idle done keeps req_n", req_n, 1);
    enq(5, 1, 2, 0, took);
    @(negedge clk);
    chk("R5 command not consumed by idle done", head_len, 5);
    serve();

    // R3 fill to full, overflow refused, order kept
    enq(3, 0, 0, 0, took); chk("R3 accept 1", took, 1);
    enq(7, 0, 0, 0, took); chk("R3 accept 2", took, 1);
    enq(11, 0, 0, 0, took); chk("R3 accept 3", took, 1);
    enq(2, 0, 0, 0, took); chk("R3 accept 4", took, 1);
    enq(9, 0, 0, 0, took); chk("R3 refused when full", took, 0);
    repeat (4) serve();
    chk("R3 queue drained", head_valid, 0);

    // random traffic
    for (int it = 0; it < 30; it++) begin
      int k;
      k = $urandom_range(1, 3);
      for (int j = 0; j < k; j++)
        if (q_len.size() < DEPTH) enq($urandom_range(0, 40), $urandom, $urandom, 0, took);
      serve();
    end
    while (q_len.size() > 0) serve();

    // R7 timeout retry of the same head
    enq(9, 0, 0, 0, took);
    cnt = 0;
    while (req_n && cnt < 16) begin @(negedge clk); cnt++; end
    for (int i = 0; i < 3; i++) begin byte_adv = 1; @(negedge clk); end
    byte_adv = 0;
    chk("R6 three bytes moved", head_pos, 3);
    cnt = 3;
    while (!req_n && cnt < TX_MS * TPM + 20) begin @(negedge clk); cnt++; end
    chk("R7 request released on timeout", req_n, 1);
    chk("R12 tx timeout window", (cnt >= (TX_MS - 1) * TPM - 2) && (cnt <= TX_MS * TPM + 3), 1);
    chk("R7 position rewound", head_pos, 0);
    chk("R7 head kept", head_len, 9);
    @(negedge clk);
    chk("R7 request again", req_n, 0);
    serve();

    // R8/R9/R10 directed synchronous routing
    enq(2, 'h12, 'h34, 1, took);
    chk("R8 sync accepted", took, 1);
    enq_sync = 1; #1 chk("R8 second sync refused", enq_ready, 0);
    enq_sync = 0; #1 chk("R8 ordinary still accepted", enq_ready, 1);
    @(negedge clk);
    rx('h12, 'h35, 0);          // differs only in byte 2
    rx('hF5, 'h34, 0);          // event code 0x85
    rx('h12, 'h34, 1);          // match
    rx('h12, 'h34, 0);          // tag cleared, now an event
    enq_sync = 1; #1 chk("R9 sync accepted again after match", enq_ready, 1);
    enq_sync = 0;
    @(negedge clk);
    serve();

    // random synchronous traffic
    for (int it = 0; it < 10; it++) begin
      c0 = $urandom_range(0, 255); c1 = $urandom_range(0, 255);
      enq(1, c0, c1, 1, took);
      chk("R8 random sync accepted", took, 1);
      pend = 1;
      for (int j = 0; j < 4; j++) begin
        if ($urandom_range(0, 1) == 1) begin h = c0; b2 = c1; end
        else begin
          h = $urandom_range(0, 255); b2 = $urandom_range(0, 255);
          if (h == c0 && b2 == c1) b2 = b2 ^ 1;
        end
        rx(h, b2, pend && h == c0 && b2 == c1);
        if (h == c0 && b2 == c1) pend = 0;
      end
      if (pend) rx(c0, c1, 1);
      serve();
    end

    // R11 synchronous timeout
    enq(4, 'h55, 'hAA, 1, took);
    cnt = 0;
    while (!sync_done && cnt < SYNC_MS * TPM + 20) begin @(negedge clk); cnt++; end
    chk("R11 sync_done on expiry", sync_done, 1);
    chk("R11 sync_ok low", sync_ok, 0);
    chk("R12 sync timeout window", (cnt >= (SYNC_MS - 1) * TPM - 2) && (cnt <= SYNC_MS * TPM + 3), 1);
    enq_sync = 1; #1 chk("R11 tag cleared", enq_ready, 1);
    enq_sync = 0;
    @(negedge clk);
    rx('h55, 'hAA, 0);
    serve();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule